// File: doc/BRIEF.md
# Two-Cycle Integer and Fractional 8x8 Multiplier

This unit multiplies two 8-bit operands and returns a 16-bit product as a high byte and a low byte, bound for one fixed register pair. A 2-bit signedness code selects unsigned by unsigned, signed by signed, or signed first operand by unsigned second operand. A separate fractional bit shifts the product left by one place, which turns the result into 1.15 fixed point. Only two flags come out: a zero flag and a carry flag.

An operation starts when `start_i` is high while the unit is idle. `busy_o` is high for the one cycle after that. The result, the flags and a one-cycle `valid_o` strobe appear exactly two cycles after the start cycle. The result and flag outputs keep their values until the next operation completes. All three signedness modes go through a single 9x9 two's-complement multiplier array, with the operands extended according to the code.

Top module: `mul8_unit`

## Requirements
- R1: With `sgn_mode_i` = 2'b00, both operands are unsigned and `{res_hi_o,res_lo_o}` equals their 16-bit product.
- R2: With `sgn_mode_i` = 2'b01, both operands are two's-complement and the result is the low 16 bits of their signed product. For example, 0x80 times 0x80 gives 0x4000.
- R3: With `sgn_mode_i` = 2'b10, `opa_i` is two's-complement and `opb_i` is unsigned, and the result is the low 16 bits of the product.
- R4: With `frac_i` = 1, the result is the mode's 16-bit product shifted left by one. Bit 0 is zero and the old bit 15 is discarded.
- R5: A start accepted in cycle t makes `valid_o` high in cycle t+2, for that one cycle only. The new result and flags appear in the same cycle and hold until the next completion.
- R6: `busy_o` is high exactly in cycle t+1 after an accepted start. A `start_i` during a busy cycle is ignored: it produces no extra `valid_o` and leaves the result unchanged.
- R7: `flag_z_o` is 1 exactly when the final 16-bit result, after any fractional shift, is zero.
- R8: `flag_c_o` equals bit 15 of the product before the fractional shift.
- R9: After reset, `valid_o`, `busy_o`, both flags and the result are 0.
- R10: The code `sgn_mode_i` = 2'b11 behaves as unsigned by unsigned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start request, accepted when not busy |
| opa_i | input | 8 | First operand |
| opb_i | input | 8 | Second operand |
| sgn_mode_i | input | 2 | 00 UU, 01 SS, 10 SU, 11 as UU |
| frac_i | input | 1 | Fractional form: shift the product left by one |
| busy_o | output | 1 | An operation is in flight |
| valid_o | output | 1 | One-cycle completion strobe |
| res_hi_o | output | 8 | Product high byte |
| res_lo_o | output | 8 | Product low byte |
| flag_z_o | output | 1 | Zero flag |
| flag_c_o | output | 1 | Carry flag |

## Verification
Any wrong operand extension or shift, or a stray stage-register state, shows up at the ports in the cycle `valid_o` rises, which is two cycles after the start. The result bytes or a flag differ from the reference model in that cycle. A mistake in the acceptance logic is visible even sooner. A lost or doubled start, or a start accepted while busy, changes `busy_o` one cycle later and `valid_o` two cycles later. The per-cycle comparison catches both kinds of fault. Corner operands such as 0x80, 0xFF and zero are run in every mode, with and without the fractional shift.

// File: rtl/mul8_pkg.sv
package mul8_pkg;
    parameter int OPW = 8;
    localparam int EXTW = OPW + 1;
    localparam int PRW  = 2 * OPW;

    typedef enum logic [1:0] {
        SGN_UU  = 2'b00,
        SGN_SS  = 2'b01,
        SGN_SU  = 2'b10,
        SGN_RSV = 2'b11
    } sgn_mode_e;

    typedef struct packed {
        logic [EXTW-1:0] a_ext;
        logic [EXTW-1:0] b_ext;
        logic            frac;
    } mul_stage_t;

    typedef struct packed {
        logic [PRW-1:0] prod;
        logic           z;
        logic           c;
    } mul_result_t;

    // index 0: first operand, index 1: second operand
    function automatic logic opnd_is_signed(sgn_mode_e m, int idx);
        if (idx == 0) return (m == SGN_SS) || (m == SGN_SU);
        return (m == SGN_SS);
    endfunction
endpackage

// File: rtl/mul8_opnd.sv
module mul8_opnd #(
    parameter int W = 8
) (
    input  logic [W-1:0] raw,
    input  logic         sign_en,
    output logic [W:0]   ext
);
    always_comb ext = {sign_en & raw[W-1], raw};
endmodule

// File: rtl/mul8_array.sv
module mul8_array #(
    parameter int W = 8,
    localparam int FW = 2 * (W + 1),
    localparam int PW = 2 * W
) (
    input  logic [W:0]    a_ext,
    input  logic [W:0]    b_ext,
    output logic [PW-1:0] raw
);
    logic signed [FW-1:0] full;
    always_comb begin
        full = $signed(a_ext) * $signed(b_ext);
        raw  = full[PW-1:0];
    end
endmodule

// File: rtl/mul8_post.sv
module mul8_post #(
    parameter int W = 8,
    localparam int PW = 2 * W
) (
    input  logic [PW-1:0] raw,
    input  logic          frac,
    output logic [PW-1:0] res,
    output logic          z,
    output logic          c
);
    always_comb begin
        res = frac ? {raw[PW-2:0], 1'b0} : raw;
        z   = (res == '0);
        c   = raw[PW-1];
    end
endmodule

// File: rtl/mul8_unit.sv
module mul8_unit
    import mul8_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic           start_i,
    input  logic [OPW-1:0] opa_i,
    input  logic [OPW-1:0] opb_i,
    input  logic [1:0]     sgn_mode_i,
    input  logic           frac_i,
    output logic           busy_o,
    output logic           valid_o,
    output logic [OPW-1:0] res_hi_o,
    output logic [OPW-1:0] res_lo_o,
    output logic           flag_z_o,
    output logic           flag_c_o
);
    localparam int NOPND = 2;

    sgn_mode_e      mode;
    logic [OPW-1:0] opnd_raw [NOPND];
    logic [EXTW-1:0] opnd_ext [NOPND];
    logic           accept;

    assign mode        = sgn_mode_e'(sgn_mode_i);
    assign opnd_raw[0] = opa_i;
    assign opnd_raw[1] = opb_i;
    assign accept      = start_i & ~busy_o;

    for (genvar i = 0; i < NOPND; i++) begin : g_opnd
        mul8_opnd #(.W(OPW)) u_opnd (
            .raw     (opnd_raw[i]),
            .sign_en (opnd_is_signed(mode, i)),
            .ext     (opnd_ext[i])
        );
    end

    mul_stage_t  stage_q;
    mul_result_t res_q;
    logic [PRW-1:0] raw_prod;
    logic [PRW-1:0] fin_prod;
    logic           fin_z;
    logic           fin_c;

    // cycle 1: capture extended operands
    always_ff @(posedge clk) begin
        if (rst) begin
            busy_o  <= 1'b0;
            stage_q <= '0;
        end else begin
            busy_o <= accept;
            if (accept) begin
                stage_q.a_ext <= opnd_ext[0];
                stage_q.b_ext <= opnd_ext[1];
                stage_q.frac  <= frac_i;
            end
        end
    end

    mul8_array #(.W(OPW)) u_array (
        .a_ext (stage_q.a_ext),
        .b_ext (stage_q.b_ext),
        .raw   (raw_prod)
    );

    mul8_post #(.W(OPW)) u_post (
        .raw  (raw_prod),
        .frac (stage_q.frac),
        .res  (fin_prod),
        .z    (fin_z),
        .c    (fin_c)
    );

    // cycle 2: register product and flags
    always_ff @(posedge clk) begin
        if (rst) begin
            valid_o <= 1'b0;
            res_q   <= '0;
        end else begin
            valid_o <= busy_o;
            if (busy_o) begin
                res_q.prod <= fin_prod;
                res_q.z    <= fin_z;
                res_q.c    <= fin_c;
            end
        end
    end

    assign res_hi_o = res_q.prod[PRW-1:OPW];
    assign res_lo_o = res_q.prod[OPW-1:0];
    assign flag_z_o = res_q.z;
    assign flag_c_o = res_q.c;
endmodule

// File: rtl/mul8_unit_chk.sv
module mul8_unit_chk (
    input logic       clk,
    input logic       rst,
    input logic       start_i,
    input logic [1:0] sgn_mode_i,
    input logic       frac_i,
    input logic       busy_o,
    input logic       valid_o,
    input logic [7:0] res_hi_o,
    input logic [7:0] res_lo_o,
    input logic       flag_z_o,
    input logic       flag_c_o
);
    assert_accept_busy_R6: assert property (@(posedge clk) disable iff (rst)
        (start_i && !busy_o) |=> busy_o);
    assert_busy_single_R6: assert property (@(posedge clk) disable iff (rst)
        busy_o |=> !busy_o);
    assert_valid_latency_R5: assert property (@(posedge clk) disable iff (rst)
        busy_o |=> valid_o);
    assert_valid_cause_R5: assert property (@(posedge clk) disable iff (rst)
        (!busy_o) |=> !valid_o);
    assert_zero_flag_R7: assert property (@(posedge clk) disable iff (rst)
        valid_o |-> (flag_z_o == ({res_hi_o, res_lo_o} == 16'h0000)));
    assert_frac_lsb_R4: assert property (@(posedge clk) disable iff (rst)
        (busy_o && $past(frac_i) && $past(start_i)) |=> (res_lo_o[0] == 1'b0));
    assert_uu_carry_R8: assert property (@(posedge clk) disable iff (rst)
        (busy_o && !$past(frac_i) && ($past(sgn_mode_i) == 2'b00) && $past(start_i))
        |=> (flag_c_o == res_hi_o[7]));
    assert_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (!valid_o && !$past(valid_o)) |-> ($stable(res_hi_o) && $stable(res_lo_o)));
endmodule

bind mul8_unit mul8_unit_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .start_i    (start_i),
    .sgn_mode_i (sgn_mode_i),
    .frac_i     (frac_i),
    .busy_o     (busy_o),
    .valid_o    (valid_o),
    .res_hi_o   (res_hi_o),
    .res_lo_o   (res_lo_o),
    .flag_z_o   (flag_z_o),
    .flag_c_o   (flag_c_o)
);

// File: tb/mul8_unit_bench.sv
module mul8_unit_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start_i = 1'b0;
    logic [7:0] opa_i = '0;
    logic [7:0] opb_i = '0;
    logic [1:0] sgn_mode_i = '0;
    logic       frac_i = 1'b0;
    logic       busy_o, valid_o, flag_z_o, flag_c_o;
    logic [7:0] res_hi_o, res_lo_o;

    int total = 0;
    int bad = 0;
    int cycles = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    mul8_unit u_mul8_unit (
        .clk(clk), .rst(rst), .start_i(start_i), .opa_i(opa_i), .opb_i(opb_i),
        .sgn_mode_i(sgn_mode_i), .frac_i(frac_i), .busy_o(busy_o), .valid_o(valid_o),
        .res_hi_o(res_hi_o), .res_lo_o(res_lo_o), .flag_z_o(flag_z_o), .flag_c_o(flag_c_o)
    );

    // behavioural reference model
    bit      m_busy, m_valid, m_z, m_c;
    int      m_res;
    int      pend_res;
    bit      pend_z, pend_c;
    string   pend_tag, m_tag;

    function automatic void calc(input logic [7:0] a, input logic [7:0] b,
                                 input logic [1:0] md, input logic fr,
                                 output int res, output bit z, output bit c,
                                 output string tag);
        int sa, sb, p, raw;
        sa = (md == 2'b01 || md == 2'b10) ? int'($signed(a)) : int'(a);
        sb = (md == 2'b01) ? int'($signed(b)) : int'(b);
        p   = sa * sb;
        raw = p & 32'hFFFF;
        res = fr ? ((raw << 1) & 32'hFFFF) : raw;
        c   = raw[15];
        z   = (res == 0);
        case (md)
            2'b00: tag = "R1";
            2'b01: tag = "R2";
            2'b10: tag = "R3";
            default: tag = "R10";
        endcase
        if (fr) tag = {tag, "/R4"};
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_busy <= 0; m_valid <= 0; m_res <= 0; m_z <= 0; m_c <= 0; m_tag <= "R9";
        end else begin
            m_valid <= m_busy;
            if (m_busy) begin
                m_res <= pend_res; m_z <= pend_z; m_c <= pend_c; m_tag <= pend_tag;
            end
            if (start_i && !m_busy) begin
                int r; bit z, c; string t;
                calc(opa_i, opb_i, sgn_mode_i, frac_i, r, z, c, t);
                pend_res <= r; pend_z <= z; pend_c <= c; pend_tag <= t;
                m_busy <= 1;
            end else begin
                m_busy <= 0;
            end
        end
    end

    task automatic chk(input string req, input int act, input int exp_v);
        total++;
        if (act != exp_v) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp_v, $time);
        end
    endtask

    always @(negedge clk) begin
        if (!rst && !done) begin
            chk("R6 busy", int'(busy_o), int'(m_busy));
            chk("R5 valid", int'(valid_o), int'(m_valid));
            chk({m_tag, " R5 result"}, int'({res_hi_o, res_lo_o}), m_res);
            chk("R7 zero", int'(flag_z_o), int'(m_z));
            chk("R8 carry", int'(flag_c_o), int'(m_c));
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            done = 1;
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic op(input logic [7:0] a, input logic [7:0] b,
                      input logic [1:0] md, input logic fr);
        @(negedge clk);
        start_i = 1; opa_i = a; opb_i = b; sgn_mode_i = md; frac_i = fr;
        @(negedge clk);
        start_i = 0;
        @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        // R9: reset state
        chk("R9 reset valid", int'(valid_o), 0);
        chk("R9 reset busy", int'(busy_o), 0);
        chk("R9 reset result", int'({res_hi_o, res_lo_o, flag_z_o, flag_c_o}), 0);
        for (int f = 0; f < 2; f++) begin
            for (int md = 0; md < 4; md++) begin
                op(8'h80, 8'h80, md[1:0], f[0]);
                op(8'hFF, 8'hFF, md[1:0], f[0]);
                op(8'h00, 8'h5A, md[1:0], f[0]);
                op(8'h7F, 8'h81, md[1:0], f[0]);
                op(8'h80, 8'h01, md[1:0], f[0]);
            end
        end
        // R2 corner with explicit value
        op(8'h80, 8'h80, 2'b01, 1'b0);
        chk("R2 0x80*0x80", int'({res_hi_o, res_lo_o}), 32'h4000);
        // R4/R8: fractional FF*FF unsigned -> FC02, carry from raw FE01
        op(8'hFF, 8'hFF, 2'b00, 1'b1);
        chk("R4 frac FFxFF", int'({res_hi_o, res_lo_o}), 32'hFC02);
        chk("R8 frac carry", int'(flag_c_o), 1);
        // R6: start held high continuously, starts during busy ignored
        @(negedge clk);
        start_i = 1; opa_i = 8'h12; opb_i = 8'h34; sgn_mode_i = 2'b00; frac_i = 0;
        repeat (9) @(negedge clk);
        start_i = 0;
        repeat (3) @(negedge clk);
        // random traffic
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk);
            start_i = ($urandom_range(0, 3) != 0);
            opa_i = 8'($urandom); opb_i = 8'($urandom);
            sgn_mode_i = 2'($urandom); frac_i = 1'($urandom);
        end
        @(negedge clk);
        start_i = 0;
        repeat (4) @(negedge clk);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule